// File: doc/BRIEF.md
# Two-Wire Management Register Slave

This block is a two-wire serial slave that gives a host access to a bank of 32 sixteen-bit management registers. Both bus lines are sampled by a system clock that runs much faster than SCL. Each line passes through a synchroniser and a glitch filter before edge detection. The slave recognises START, repeated START and STOP conditions, matches a fixed 7-bit device address, and accepts a one-byte register pointer. It then moves a single 16-bit word as two bytes, high byte first. It acknowledges by pulling SDA low through an open-drain enable. It never drives SDA high.

The register bank sits outside the block and uses a plain port. The port carries the register number, the write word with a one-cycle write pulse, a one-cycle read strobe, and a combinational read word. A write reaches the bank only when both data bytes have been transferred. The read strobe fires once for each word the host reads in full, so clear-on-read registers in the bank change state exactly once.

Top module: `mgmt_i2c_slave`

## Requirements
- R1: After reset, sda_oe, reg_we and reg_re are all 0.
- R2: An address byte whose upper seven bits are 1010110 is acknowledged (SDA held low during the ninth clock). Its last bit selects the direction, with 1 meaning read. Any other address is not acknowledged, and the rest of that transaction causes no bank activity.
- R3: A pointer byte of the form 000yyyyy is acknowledged and selects register yyyyy. A pointer whose top three bits are not all zero is not acknowledged, and the data bytes after it are ignored.
- R4: In a write, each of the two data bytes is acknowledged. After the acknowledge clock of the second byte, reg_we pulses for exactly one cycle. At that pulse, reg_addr holds the pointer and reg_wdata holds {first byte, second byte}.
- R5: A STOP that follows only one data byte produces no write.
- R6: A read is a pointer write, then a repeated START, then the address with the read bit set. The slave returns the selected register's high byte and then its low byte, each most significant bit first.
- R7: reg_re pulses for exactly one cycle when the master's acknowledge clock ends after the second byte of a read, and only then. A read that the master NACKs after the high byte produces no strobe. reg_we and reg_re are never high together.
- R8: A third data byte after a completed write is not acknowledged and does not cause a second write.
- R9: A pulse on SCL shorter than FILT_LEN system clocks is ignored and does not shift in a data bit.
- R10: sda_oe changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 20 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr | output | 5 | Register number for the bank |
| reg_wdata | output | 16 | Word to write |
| reg_we | output | 1 | One-cycle write pulse |
| reg_re | output | 1 | One-cycle strobe for a completed read |
| reg_rdata | input | 16 | Contents of the register at reg_addr |

## Verification
On every cycle, the bound checker enforces several rules. The write and read pulses last a single cycle and never overlap. SDA is released whenever either pulse fires. The open-drain enable never moves while SCL is high. Several properties can only be shown by the bench's directed transactions, because they span whole byte sequences. These include address and pointer matching, the order and packing of the two data bytes, and the discarding of half-written words. They also include the single strobe on a clear-on-read register, and the rejection of a short SCL glitch.

// File: rtl/mgmt_i2c_pkg.sv
package mgmt_i2c_pkg;

   // Position of the sequencer within one bus transaction
   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_ADDR  = 3'd1,
      PH_PTR   = 3'd2,
      PH_WDATA = 3'd3,
      PH_RDATA = 3'd4,
      PH_SKIP  = 3'd5
   } phase_e;

   localparam int unsigned BITS_PER_BYTE = 8;

endpackage

// File: rtl/mgmt_line_filter.sv
// Two-flop synchroniser followed by a persistence filter: the output
// follows the input only after FILT_LEN consecutive differing samples.
module mgmt_line_filter #(
   parameter int unsigned FILT_LEN = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);
   localparam int unsigned CW = $clog2(FILT_LEN + 1);

   logic          s1_q, s2_q, out_q;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_q  <= 1'b1;
         s2_q  <= 1'b1;
         out_q <= 1'b1;
         cnt_q <= '0;
      end else begin
         s1_q <= line_i;
         s2_q <= s1_q;
         if (s2_q == out_q) begin
            cnt_q <= '0;
         end else if (cnt_q == CW'(FILT_LEN - 1)) begin
            out_q <= s2_q;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + CW'(1);
         end
      end
   end

   assign line_o = out_q;
endmodule

// File: rtl/mgmt_bus_events.sv
// Turns the cleaned SCL/SDA levels into single-cycle event pulses.
module mgmt_bus_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_c,
   input  logic sda_c,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_d <= scl_c;
         sda_d <= sda_c;
      end
   end

   assign scl_rise  =  scl_c & ~scl_d;
   assign scl_fall  = ~scl_c &  scl_d;
   assign start_det =  scl_c &  scl_d &  sda_d & ~sda_c;
   assign stop_det  =  scl_c &  scl_d & ~sda_d &  sda_c;
endmodule

// File: rtl/mgmt_i2c_slave.sv
module mgmt_i2c_slave
   import mgmt_i2c_pkg::*;
#(
   parameter logic [6:0]  DEV_ADDR  = 7'b1010110,
   parameter int unsigned REG_COUNT = 32,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned FILT_LEN  = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          scl_i,
   input  logic                          sda_i,
   output logic                          sda_oe,
   output logic [$clog2(REG_COUNT)-1:0]  reg_addr,
   output logic [DATA_W-1:0]             reg_wdata,
   output logic                          reg_we,
   output logic                          reg_re,
   input  logic [DATA_W-1:0]             reg_rdata
);
   localparam int unsigned AW = $clog2(REG_COUNT);
   localparam int unsigned NB = DATA_W / BITS_PER_BYTE;
   localparam int unsigned BW = (NB > 1) ? $clog2(NB) : 1;

   // Elaboration-time parameter checks
   if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_width
      $error("DATA_W must be a multiple of 8 and at least 16");
   end
   if (REG_COUNT < 2 || REG_COUNT > 256 || (1 << AW) != REG_COUNT) begin : g_bad_count
      $error("REG_COUNT must be a power of two between 2 and 256");
   end
   if (FILT_LEN < 1) begin : g_bad_filt
      $error("FILT_LEN must be at least 1");
   end

   // Line conditioning, one filter per bus line
   logic [1:0] raw_lines, clean_lines;
   assign raw_lines = {scl_i, sda_i};

   for (genvar gl = 0; gl < 2; gl++) begin : g_line
      mgmt_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
         .clk    (clk),
         .rst_n  (rst_n),
         .line_i (raw_lines[gl]),
         .line_o (clean_lines[gl])
      );
   end

   logic scl_c, sda_c;
   assign scl_c = clean_lines[1];
   assign sda_c = clean_lines[0];

   logic scl_rise, scl_fall, start_det, stop_det;

   mgmt_bus_events u_events (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_c     (scl_c),
      .sda_c     (sda_c),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   // Sequencer state
   phase_e              phase_q;
   logic                ack_ph_q;
   logic [3:0]          bitcnt_q;
   logic [7:0]          shreg_q;
   logic                rw_q;
   logic                mack_q;
   logic [AW-1:0]       ptr_q;
   logic [BW-1:0]       bidx_q;
   logic [DATA_W-1:0]   wbuf_q;
   logic [DATA_W-1:0]   tx_q;
   logic                sda_oe_q, we_q, re_q;

   // Pointer range check: variant picked by the register count
   logic ptr_ok;
   if (AW < 8) begin : g_ptr_narrow
      assign ptr_ok = (shreg_q[7:AW] == '0);
   end else begin : g_ptr_full
      assign ptr_ok = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         ack_ph_q <= 1'b0;
         bitcnt_q <= '0;
         shreg_q  <= '0;
         rw_q     <= 1'b0;
         mack_q   <= 1'b0;
         ptr_q    <= '0;
         bidx_q   <= '0;
         wbuf_q   <= '0;
         tx_q     <= '0;
         sda_oe_q <= 1'b0;
         we_q     <= 1'b0;
         re_q     <= 1'b0;
      end else begin
         we_q <= 1'b0;
         re_q <= 1'b0;
         if (start_det) begin
            phase_q  <= PH_ADDR;
            ack_ph_q <= 1'b0;
            bitcnt_q <= '0;
            bidx_q   <= '0;
            sda_oe_q <= 1'b0;
         end else if (stop_det) begin
            phase_q  <= PH_IDLE;
            ack_ph_q <= 1'b0;
            sda_oe_q <= 1'b0;
         end else begin
            unique case (phase_q)
               PH_ADDR, PH_PTR, PH_WDATA: begin
                  if (!ack_ph_q) begin
                     if (scl_rise) begin
                        shreg_q  <= {shreg_q[6:0], sda_c};
                        bitcnt_q <= bitcnt_q + 4'd1;
                     end else if (scl_fall && bitcnt_q == 4'd8) begin
                        bitcnt_q <= '0;
                        if (phase_q == PH_ADDR) begin
                           if (shreg_q[7:1] == DEV_ADDR) begin
                              ack_ph_q <= 1'b1;
                              sda_oe_q <= 1'b1;
                              rw_q     <= shreg_q[0];
                           end else begin
                              phase_q <= PH_SKIP;
                           end
                        end else if (phase_q == PH_PTR) begin
                           if (ptr_ok) begin
                              ack_ph_q <= 1'b1;
                              sda_oe_q <= 1'b1;
                              ptr_q    <= shreg_q[AW-1:0];
                           end else begin
                              phase_q <= PH_SKIP;
                           end
                        end else begin
                           ack_ph_q <= 1'b1;
                           sda_oe_q <= 1'b1;
                           wbuf_q   <= {wbuf_q[DATA_W-9:0], shreg_q};
                        end
                     end
                  end else if (scl_fall) begin
                     ack_ph_q <= 1'b0;
                     sda_oe_q <= 1'b0;
                     if (phase_q == PH_ADDR) begin
                        if (rw_q) begin
                           phase_q  <= PH_RDATA;
                           tx_q     <= reg_rdata;
                           sda_oe_q <= ~reg_rdata[DATA_W-1];
                           bidx_q   <= '0;
                        end else begin
                           phase_q <= PH_PTR;
                        end
                     end else if (phase_q == PH_PTR) begin
                        phase_q <= PH_WDATA;
                        bidx_q  <= '0;
                     end else if (bidx_q == BW'(NB - 1)) begin
                        we_q    <= 1'b1;
                        phase_q <= PH_SKIP;
                     end else begin
                        bidx_q <= bidx_q + BW'(1);
                     end
                  end
               end
               PH_RDATA: begin
                  if (!ack_ph_q) begin
                     if (scl_fall) begin
                        tx_q <= {tx_q[DATA_W-2:0], 1'b0};
                        if (bitcnt_q == 4'd7) begin
                           bitcnt_q <= '0;
                           ack_ph_q <= 1'b1;
                           sda_oe_q <= 1'b0;
                        end else begin
                           bitcnt_q <= bitcnt_q + 4'd1;
                           sda_oe_q <= ~tx_q[DATA_W-2];
                        end
                     end
                  end else if (scl_rise) begin
                     mack_q <= ~sda_c;
                  end else if (scl_fall) begin
                     ack_ph_q <= 1'b0;
                     if (bidx_q == BW'(NB - 1)) begin
                        re_q    <= 1'b1;
                        phase_q <= PH_SKIP;
                     end else if (mack_q) begin
                        bidx_q   <= bidx_q + BW'(1);
                        sda_oe_q <= ~tx_q[DATA_W-1];
                     end else begin
                        phase_q <= PH_SKIP;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe    = sda_oe_q;
   assign reg_addr  = ptr_q;
   assign reg_wdata = wbuf_q;
   assign reg_we    = we_q;
   assign reg_re    = re_q;
endmodule

// File: rtl/mgmt_i2c_slave_chk.sv
module mgmt_i2c_slave_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_i,
   input logic sda_oe,
   input logic reg_we,
   input logic reg_re
);
   // R4
   we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   // R7
   re_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_re |=> !reg_re);

   // R7
   bank_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && reg_re));

   // R4
   we_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> !sda_oe);

   // R7
   re_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_re |-> !sda_oe);

   // R10
   sda_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_i);
endmodule

bind mgmt_i2c_slave mgmt_i2c_slave_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .scl_i  (scl_i),
   .sda_oe (sda_oe),
   .reg_we (reg_we),
   .reg_re (reg_re)
);

// File: tb/sim_mgmt_i2c_slave.sv
`timescale 1ns/1ps
module sim_mgmt_i2c_slave;
   localparam int Q = 20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1;
   logic        sda_m = 1'b1;
   logic        sda_oe;
   logic [4:0]  reg_addr;
   logic [15:0] reg_wdata;
   logic        reg_we, reg_re;
   logic [15:0] reg_rdata;
   logic        sda_line;

   int errors = 0;
   int checks = 0;
   int we_cnt = 0;
   int re_cnt = 0;
   int r10_viol = 0;
   logic [15:0] bank [32];

   always #10 clk = ~clk;

   assign sda_line  = sda_m & ~sda_oe;
   assign reg_rdata = bank[reg_addr];

   mgmt_i2c_slave u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_m),
      .sda_i     (sda_line),
      .sda_oe    (sda_oe),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_we    (reg_we),
      .reg_re    (reg_re),
      .reg_rdata (reg_rdata)
   );

   // Bank model; register 21 clears when a read of it completes
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 32; i++) bank[i] <= 16'h0000;
         bank[9] <= 16'hA5C3;
      end else begin
         if (reg_we) begin
            bank[reg_addr] <= reg_wdata;
            we_cnt++;
         end
         if (reg_re) begin
            re_cnt++;
            if (reg_addr == 5'd21) bank[21] <= 16'h0000;
         end
      end
   end

   // R10 monitor: the enable may only move while SCL is low
   logic oe_prev = 1'b0;
   always @(negedge clk) begin
      if (rst_n && sda_oe != oe_prev && scl_m) r10_viol++;
      oe_prev = sda_oe;
   end

   task automatic chk_eq(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wt(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wt(Q);
      scl_m = 1'b1; wt(Q);
      sda_m = 1'b0; wt(Q);
      scl_m = 1'b0; wt(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wt(Q);
      scl_m = 1'b1; wt(Q);
      sda_m = 1'b1; wt(2*Q);
   endtask

   task automatic put_bit(bit b, bit glitch);
      sda_m = b;
      if (glitch) begin
         wt(8); scl_m = 1'b1; wt(2); scl_m = 1'b0; wt(Q-10);
      end else begin
         wt(Q);
      end
      scl_m = 1'b1; wt(2*Q);
      scl_m = 1'b0; wt(Q);
   endtask

   task automatic get_bit(output bit b);
      sda_m = 1'b1; wt(Q);
      scl_m = 1'b1; wt(Q);
      b = sda_line; wt(Q);
      scl_m = 1'b0; wt(Q);
   endtask

   task automatic send_byte(input logic [7:0] v, input bit gl, output bit ack);
      bit b;
      for (int i = 7; i >= 0; i--) put_bit(v[i], gl && (i == 4));
      get_bit(b);
      ack = ~b;
   endtask

   task automatic recv_byte(input bit ack, output logic [7:0] v);
      bit b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      put_bit(~ack, 1'b0);
   endtask

   task automatic do_write(logic [4:0] ptr, logic [15:0] val, bit gl, string req);
      bit a;
      int n0;
      n0 = we_cnt;
      bus_start();
      send_byte(8'hAC, 1'b0, a); chk_eq("R2", "write address ack", a, 1);
      send_byte({3'b000, ptr}, 1'b0, a); chk_eq("R3", "pointer ack", a, 1);
      send_byte(val[15:8], gl, a); chk_eq(req, "high byte ack", a, 1);
      send_byte(val[7:0], 1'b0, a); chk_eq(req, "low byte ack", a, 1);
      bus_stop();
      chk_eq(req, "write pulses", we_cnt - n0, 1);
      chk_eq(req, "bank word", bank[ptr], val);
   endtask

   task automatic do_read(logic [4:0] ptr, output logic [15:0] val);
      bit a;
      logic [7:0] hi, lo;
      bus_start();
      send_byte(8'hAC, 1'b0, a); chk_eq("R6", "pointer phase ack", a, 1);
      send_byte({3'b000, ptr}, 1'b0, a); chk_eq("R6", "read pointer ack", a, 1);
      bus_start();
      send_byte(8'hAD, 1'b0, a); chk_eq("R2", "read address ack", a, 1);
      recv_byte(1'b1, hi);
      recv_byte(1'b0, lo);
      bus_stop();
      val = {hi, lo};
   endtask

   task automatic t_reset();
      chk_eq("R1", "sda_oe at reset", sda_oe, 0);
      chk_eq("R1", "reg_we at reset", reg_we, 0);
      chk_eq("R1", "reg_re at reset", reg_re, 0);
   endtask

   task automatic t_write_read();
      logic [15:0] v;
      int r0;
      do_write(5'd5, 16'hBEEF, 1'b0, "R4");
      r0 = re_cnt;
      do_read(5'd5, v);
      chk_eq("R6", "read back reg 5", v, 16'hBEEF);
      chk_eq("R7", "strobe per read", re_cnt - r0, 1);
      do_write(5'd31, 16'h0102, 1'b0, "R4");
      do_read(5'd31, v);
      chk_eq("R6", "read back reg 31", v, 16'h0102);
      do_read(5'd9, v);
      chk_eq("R6", "read preset reg 9", v, 16'hA5C3);
   endtask

   task automatic t_wrong_addr();
      bit a;
      int n0;
      n0 = we_cnt;
      bus_start();
      send_byte(8'hAE, 1'b0, a); chk_eq("R2", "foreign address nack", a, 0);
      send_byte(8'h03, 1'b0, a);
      send_byte(8'h12, 1'b0, a);
      send_byte(8'h34, 1'b0, a);
      bus_stop();
      chk_eq("R2", "no write for foreign address", we_cnt - n0, 0);
      chk_eq("R2", "reg 3 untouched", bank[3], 16'h0000);
   endtask

   task automatic t_bad_ptr();
      bit a;
      int n0;
      n0 = we_cnt;
      bus_start();
      send_byte(8'hAC, 1'b0, a);
      send_byte(8'h25, 1'b0, a); chk_eq("R3", "bad pointer nack", a, 0);
      send_byte(8'h55, 1'b0, a); chk_eq("R3", "data after bad pointer nack", a, 0);
      send_byte(8'h66, 1'b0, a);
      bus_stop();
      chk_eq("R3", "no write after bad pointer", we_cnt - n0, 0);
      chk_eq("R3", "reg 5 untouched", bank[5], 16'hBEEF);
   endtask

   task automatic t_partial();
      bit a;
      int n0;
      n0 = we_cnt;
      bus_start();
      send_byte(8'hAC, 1'b0, a);
      send_byte(8'h06, 1'b0, a);
      send_byte(8'h77, 1'b0, a); chk_eq("R5", "single byte ack", a, 1);
      bus_stop();
      chk_eq("R5", "no write on half word", we_cnt - n0, 0);
      chk_eq("R5", "reg 6 untouched", bank[6], 16'h0000);
   endtask

   task automatic t_third_byte();
      bit a;
      int n0;
      n0 = we_cnt;
      bus_start();
      send_byte(8'hAC, 1'b0, a);
      send_byte(8'h07, 1'b0, a);
      send_byte(8'hC0, 1'b0, a);
      send_byte(8'hDE, 1'b0, a);
      send_byte(8'h99, 1'b0, a); chk_eq("R8", "third byte nack", a, 0);
      bus_stop();
      chk_eq("R8", "exactly one write", we_cnt - n0, 1);
      chk_eq("R8", "reg 7 holds first word", bank[7], 16'hC0DE);
   endtask

   task automatic t_clear_on_read();
      logic [15:0] v;
      int r0;
      do_write(5'd21, 16'h1234, 1'b0, "R4");
      r0 = re_cnt;
      do_read(5'd21, v);
      chk_eq("R7", "first read of reg 21", v, 16'h1234);
      chk_eq("R7", "one strobe first read", re_cnt - r0, 1);
      do_read(5'd21, v);
      chk_eq("R7", "second read after clear", v, 16'h0000);
      chk_eq("R7", "one strobe second read", re_cnt - r0, 2);
   endtask

   task automatic t_abort_read();
      bit a;
      logic [7:0] hi;
      int r0;
      r0 = re_cnt;
      bus_start();
      send_byte(8'hAC, 1'b0, a);
      send_byte(8'h05, 1'b0, a);
      bus_start();
      send_byte(8'hAD, 1'b0, a);
      recv_byte(1'b0, hi);
      bus_stop();
      chk_eq("R6", "high byte of aborted read", hi, 8'hBE);
      chk_eq("R7", "no strobe on aborted read", re_cnt - r0, 0);
   endtask

   task automatic t_glitch();
      logic [15:0] v;
      do_write(5'd10, 16'h5A3C, 1'b1, "R9");
      do_read(5'd10, v);
      chk_eq("R9", "word written across glitch", v, 16'h5A3C);
   endtask

   initial begin
      wt(5);
      rst_n = 1'b1;
      wt(5);
      t_reset();
      t_write_read();
      t_wrong_addr();
      t_bad_ptr();
      t_partial();
      t_third_byte();
      t_clear_on_read();
      t_abort_read();
      t_glitch();
      chk_eq("R10", "enable moves with SCL high", r10_viol, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule